// File: doc/BRIEF.md
# H-Bridge PWM Generator with Minimum Off-Time Clamp

This block drives an H-bridge motor driver. It makes a fixed-frequency pulse-width signal and a complementary pair of direction lines. With the default parameters it runs from a 50 MHz clock and produces a 20 kHz waveform, so one period is 2500 clock cycles. An 8-bit duty command sets the high time. A single direction bit selects forward or reverse.

Each period the duty command is scaled onto the period length. The result is then limited so that the output always stays low for at least 6 µs (300 cycles). The driver's short-circuit detection needs that low interval to avoid false trips, and the limit keeps it even under a full-scale command. Commands are taken only at a period boundary, so a change never cuts a pulse short or stretches it.

Top module: `hbridge_pwm`

## Requirements
- R1: The internal period counter counts 0 to 2499 and wraps, so every PWM period is exactly 2500 clock cycles. The first cycle after reset release is cycle 0 of a period.
- R2: The high time of a period equals min(floor(duty×2500/256), 2200) cycles, where duty is the 8-bit command taken for that period (for example 0x80 gives 1250, 0x40 gives 625, 0xE1 gives 2197, and 0xE2 and 0xFF give 2200).
- R3: In every period `pwmOut` is low for at least 300 cycles.
- R4: The high interval is one contiguous run that starts at cycle 0 of the period. After the output first goes low in a period, it does not go high again in that period.
- R5: With `dirRev`=0 (forward) the outputs are `ina`=1 and `inb`=0. With `dirRev`=1 (reverse) they are `ina`=0 and `inb`=1.
- R6: A duty command of 0x00 keeps `pwmOut` low for the whole period.
- R7: `dutyIn` and `dirRev` are sampled only on the clock edge where the counter wraps from 2499 to 0. A change at any other time has no effect on `pwmOut`, `ina` or `inb` until the next period starts.
- R8: While `rst` (synchronous, active high) is asserted, the counter is cleared, `pwmOut` is low, the direction is forward and the stored duty is 0. The first period after reset is therefore all low and forward, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock (50 MHz by default) |
| rst | input | 1 | Synchronous active-high reset |
| dutyIn | input | 8 | Duty command, 0x00 to 0xFF |
| dirRev | input | 1 | Direction: 0 forward, 1 reverse |
| ina | output | 1 | Bridge direction line A (high when forward) |
| inb | output | 1 | Bridge direction line B (high when reverse) |
| pwmOut | output | 1 | Clamped pulse-width output |

## Verification
`pwmOut`, `ina` and `inb` are registered in step with the counter. A command that is present on the final cycle of a period shows up on the very first cycle of the next period. A command changed in the middle of a period waits until the following wrap, which is 2500 minus its position cycles away. The bench samples at falling edges. It applies each command on the falling edge of a period's last cycle, then measures the next 2500 samples as one period, so the expected high count, the low count and the direction all line up with whole periods. To show that mid-period changes are held off, the bench changes the inputs partway through some periods and checks that the measured period still matches the command taken at its start.

// File: rtl/hb_pwm_pkg.sv
package hb_pwm_pkg;

  // Strobes from the control section to the datapath.
  typedef struct packed {
    logic clear;  // synchronous reset of all datapath state
    logic load;   // period wrap: take a new command
  } pwm_strobe_t;

endpackage

// File: rtl/hb_pwm_ctrl.sv
module hb_pwm_ctrl
  import hb_pwm_pkg::*;
#(
  parameter int PERIOD = 2500,
  parameter int CNT_W  = 12
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt,
  output pwm_strobe_t      strb
);

  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(PERIOD - 1);

  logic atLast;

  assign atLast     = (cnt == LAST_IDX);
  assign strb.load  = atLast;
  assign strb.clear = rst;

  always_ff @(posedge clk) begin
    if (rst)         cnt <= '0;
    else if (atLast) cnt <= '0;
    else             cnt <= cnt + CNT_W'(1);
  end

  // R1: the counter never leaves its range
  a_r1_cnt_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST_IDX);

  // R1: the last index is followed by zero
  a_r1_wrap: assert property (@(posedge clk) disable iff (rst)
    (cnt == LAST_IDX) |=> (cnt == '0));

  // R1: otherwise the counter advances by one
  a_r1_step: assert property (@(posedge clk) disable iff (rst)
    (cnt != LAST_IDX) |=> (cnt == $past(cnt) + CNT_W'(1)));

endmodule

// File: rtl/hb_pwm_thresh.sv
module hb_pwm_thresh #(
  parameter int DUTY_W  = 8,
  parameter int PERIOD  = 2500,
  parameter int MIN_OFF = 300,
  parameter int CNT_W   = 12
) (
  input  logic [DUTY_W-1:0] duty,
  output logic [CNT_W-1:0]  rawThr,
  output logic [CNT_W-1:0]  effThr
);

  localparam int PROD_W = DUTY_W + CNT_W;
  localparam logic [CNT_W-1:0] MAX_HI = CNT_W'(PERIOD - MIN_OFF);

  logic [PROD_W-1:0] prod;

  // duty * PERIOD / 2^DUTY_W, truncated
  assign prod   = PROD_W'(duty) * PROD_W'(PERIOD);
  assign rawThr = prod[PROD_W-1:DUTY_W];
  assign effThr = (rawThr > MAX_HI) ? MAX_HI : rawThr;

  // R2: the clamped threshold never exceeds the raw one or the cap
  always_comb begin
    a_r2_clamp_bound: assert (effThr <= MAX_HI && effThr <= rawThr);
  end

endmodule

// File: rtl/hb_pwm_datapath.sv
module hb_pwm_datapath
  import hb_pwm_pkg::*;
#(
  parameter int DUTY_W  = 8,
  parameter int PERIOD  = 2500,
  parameter int MIN_OFF = 300,
  parameter int CNT_W   = 12
) (
  input  logic              clk,
  input  pwm_strobe_t       strb,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [DUTY_W-1:0] dutyIn,
  input  logic              dirRev,
  output logic              ina,
  output logic              inb,
  output logic              pwmOut
);

  localparam logic [CNT_W-1:0] MAX_HI = CNT_W'(PERIOD - MIN_OFF);

  logic [DUTY_W-1:0] dutyQ;
  logic              dirQ;
  logic [CNT_W-1:0]  thrQ;
  logic              pwmQ;
  logic [CNT_W-1:0]  rawNew;
  logic [CNT_W-1:0]  thrNew;
  logic [CNT_W-1:0]  cntNext;
  logic              pwmNext;

  hb_pwm_thresh #(
    .DUTY_W (DUTY_W),
    .PERIOD (PERIOD),
    .MIN_OFF(MIN_OFF),
    .CNT_W  (CNT_W)
  ) u_thresh (
    .duty  (dutyIn),
    .rawThr(rawNew),
    .effThr(thrNew)
  );

  assign cntNext = cnt + CNT_W'(1);

  // The output is registered in step with the counter: it is high on
  // the cycle where the counter holds k exactly when k < threshold.
  always_comb begin
    if (strb.load) pwmNext = (thrNew != '0);
    else           pwmNext = (cntNext < thrQ);
  end

  always_ff @(posedge clk) begin
    if (strb.clear) begin
      dutyQ <= '0;
      dirQ  <= 1'b0;
      thrQ  <= '0;
      pwmQ  <= 1'b0;
    end else begin
      if (strb.load) begin
        dutyQ <= dutyIn;
        dirQ  <= dirRev;
        thrQ  <= thrNew;
      end
      pwmQ <= pwmNext;
    end
  end

  assign pwmOut = pwmQ;
  assign ina    = ~dirQ;
  assign inb    = dirQ;

  // R3: the tail of every period is low
  a_r3_min_off: assert property (@(posedge clk) disable iff (strb.clear)
    (cnt >= MAX_HI) |-> !pwmOut);

  // R4: once low inside a period, the output stays low until the wrap
  a_r4_single_run: assert property (@(posedge clk) disable iff (strb.clear)
    (!pwmOut && cnt != CNT_W'(PERIOD - 1)) |=> !pwmOut);

  // R6: a stored zero duty gives no high cycle
  a_r6_zero_low: assert property (@(posedge clk) disable iff (strb.clear)
    (dutyQ == '0) |-> !pwmOut);

  // R7: the command registers change only at a wrap
  a_r7_hold: assert property (@(posedge clk) disable iff (strb.clear)
    !strb.load |=> ($stable(dutyQ) && $stable(dirQ) && $stable(thrQ)));

  // R8: the cycle after a reset edge is low and forward
  a_r8_reset_state: assert property (@(posedge clk)
    $past(strb.clear) |-> (!pwmOut && ina && !inb));

endmodule

// File: rtl/hbridge_pwm.sv
module hbridge_pwm
  import hb_pwm_pkg::*;
#(
  parameter int CLK_HZ     = 50_000_000,
  parameter int PWM_HZ     = 20_000,
  parameter int MIN_OFF_NS = 6_000,
  parameter int DUTY_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DUTY_W-1:0] dutyIn,
  input  logic              dirRev,
  output logic              ina,
  output logic              inb,
  output logic              pwmOut
);

  localparam int PERIOD  = CLK_HZ / PWM_HZ;
  localparam int MIN_OFF = ((CLK_HZ / 1000) * MIN_OFF_NS) / 1_000_000;
  localparam int CNT_W   = $clog2(PERIOD);

  logic [CNT_W-1:0] cnt;
  pwm_strobe_t      strb;

  hb_pwm_ctrl #(
    .PERIOD(PERIOD),
    .CNT_W (CNT_W)
  ) u_ctrl (
    .clk (clk),
    .rst (rst),
    .cnt (cnt),
    .strb(strb)
  );

  hb_pwm_datapath #(
    .DUTY_W (DUTY_W),
    .PERIOD (PERIOD),
    .MIN_OFF(MIN_OFF),
    .CNT_W  (CNT_W)
  ) u_dp (
    .clk   (clk),
    .strb  (strb),
    .cnt   (cnt),
    .dutyIn(dutyIn),
    .dirRev(dirRev),
    .ina   (ina),
    .inb   (inb),
    .pwmOut(pwmOut)
  );

endmodule

// File: tb/sim_hbridge_pwm.sv
module sim_hbridge_pwm;

  localparam int PER  = 2500;
  localparam int CAP  = 2200;
  localparam int MINL = 300;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] dutyIn = 8'h00;
  logic       dirRev = 1'b0;
  logic       ina, inb, pwmOut;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  hbridge_pwm u0 (
    .clk   (clk),
    .rst   (rst),
    .dutyIn(dutyIn),
    .dirRev(dirRev),
    .ina   (ina),
    .inb   (inb),
    .pwmOut(pwmOut)
  );

  function automatic int expHigh(input logic [7:0] d);
    int raw;
    raw = (int'(d) * PER) / 256;
    return (raw > CAP) ? CAP : raw;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Called on the falling edge inside the last cycle of a period.
  task automatic runPeriod(input logic [7:0] d, input logic r,
                           input bit mid, input logic [7:0] md,
                           input logic mr);
    int  hi = 0, lo = 0, gap = 0, dirBad = 0, exp;
    bit  seenLow = 0, firstHi = 0;
    exp    = expHigh(d);
    dutyIn = d;
    dirRev = r;
    for (int i = 0; i < PER; i++) begin
      @(negedge clk);
      if (i == 0) firstHi = pwmOut;
      if (pwmOut === 1'b1) begin
        hi++;
        if (seenLow) gap++;
      end else begin
        lo++;
        seenLow = 1;
      end
      if (ina !== ~r || inb !== r) dirBad++;
      if (mid && i == 1200) begin
        dutyIn = md;
        dirRev = mr;
      end
    end
    chk(hi == exp, "R2", "high count", hi, exp);
    chk(lo >= MINL, "R3", "low count", lo, MINL);
    chk(gap == 0, "R4", "high after low", gap, 0);
    chk(int'(firstHi) == int'(exp > 0), "R1", "period start level",
        int'(firstHi), int'(exp > 0));
    chk(dirBad == 0, "R5", "direction mismatches", dirBad, 0);
    if (d == 8'h00) chk(hi == 0, "R6", "zero duty high", hi, 0);
    if (mid) chk(hi == exp && dirBad == 0, "R7", "mid-period change leaked",
                 hi, exp);
  endtask

  initial begin
    int hi0, dirBad0;
    void'($urandom(32'd20240611));
    // Inputs hostile during reset: reset state must win (R8)
    dutyIn = 8'hFF;
    dirRev = 1'b1;
    rst    = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(pwmOut === 1'b0 && ina === 1'b1 && inb === 1'b0, "R8",
        "reset outputs {pwm,ina,inb}", {pwmOut, ina, inb}, 3'b010);
    hi0 = 0;
    dirBad0 = 0;
    for (int i = 0; i < PER; i++) begin
      if (i != 0) @(negedge clk);
      if (pwmOut === 1'b1) hi0++;
      if (ina !== 1'b1 || inb !== 1'b0) dirBad0++;
    end
    chk(hi0 == 0, "R8", "first period high count", hi0, 0);
    chk(dirBad0 == 0, "R8", "first period direction", dirBad0, 0);

    // Directed sequence
    runPeriod(8'h00, 1'b0, 0, 8'h00, 1'b0);
    runPeriod(8'h80, 1'b0, 0, 8'h00, 1'b0);
    runPeriod(8'hFF, 1'b0, 0, 8'h00, 1'b0);
    runPeriod(8'h40, 1'b1, 0, 8'h00, 1'b0);
    runPeriod(8'hFF, 1'b1, 0, 8'h00, 1'b0);
    runPeriod(8'h01, 1'b0, 0, 8'h00, 1'b0);
    runPeriod(8'hE1, 1'b1, 0, 8'h00, 1'b0);
    runPeriod(8'hE2, 1'b0, 0, 8'h00, 1'b0);
    runPeriod(8'h40, 1'b0, 1, 8'hFF, 1'b1);
    runPeriod(8'hFF, 1'b1, 1, 8'h00, 1'b0);
    runPeriod(8'h00, 1'b0, 1, 8'hC0, 1'b1);

    // Random commands, some with mid-period changes
    for (int k = 0; k < 16; k++) begin
      logic [7:0] d, md;
      logic       r, mr;
      bit         mid;
      d   = 8'($urandom);
      md  = 8'($urandom);
      r   = 1'($urandom);
      mr  = 1'($urandom);
      mid = 1'($urandom);
      runPeriod(d, r, mid, md, mr);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule